// File: doc/BRIEF.md
# I2C SCL Clock Timing Generator

This block turns a system clock into the serial clock of an I2C controller. A 32-bit timing word selects a power-of-two prescale exponent and two phase counts, one for the time SCL is held low and one for the time it is released. Each phase count is stored as its value minus one, so a stored zero still lasts one prescaled tick. A full SCL period therefore lasts `(1 << base) * ((high + 1) + (low + 1))` system clock cycles.

A byte engine uses the outputs. `scl_drive_o` asks the pad to pull SCL low. One-cycle strobes mark the start of each low phase (the falling edge) and the start of each high phase (the rising edge). Two more strobes mark the middle of the low phase, where SDA may change, and the middle of the high phase, where SDA is sampled. The timing word sits in a local register. Its upper twelve bits hold other bus timing fields that this block only stores. A divisor-only write leaves those bits untouched. The phase fields are 4 bits wide by default, and a parameter narrows them to 3 bits.

Top module: `scl_timing_gen`

## Requirements
- R1: While `rst_ni` is low, `scl_drive_o` and all four strobes are 0. In the cycle after `en_i` is sampled low, `scl_drive_o` is 0 and no strobe is raised until `en_i` returns high.
- R2: After `en_i` is sampled high from the disabled state, the next cycle starts a low phase. A low phase lasts `(lo+1)<<base` cycles with `scl_drive_o`=1. It is followed by a high phase of `(hi+1)<<base` cycles with `scl_drive_o`=0. The two phases then repeat.
- R3: In the timing word, `base` is bits 3:0 (0 to 15, a prescale factor of 1 to 32768). `hi` starts at bit 16 and `lo` starts at bit 12. Each is `HL_W` bits wide.
- R4: `scl_fall_o` pulses for one cycle in the first cycle of each low phase. `scl_rise_o` pulses for one cycle in the first cycle of each high phase.
- R5: `mid_low_o` pulses at offset `floor(Llow/2)` into the low phase, and `mid_high_o` at offset `floor(Lhigh/2)` into the high phase. Offset 0 is the edge cycle, so for a one-cycle phase the mid strobe coincides with the edge strobe.
- R6: The generator takes base, hi and lo from the timing register only when a low phase starts. A write during a period changes nothing until the next period.
- R7: Disabling the generator clears the prescaler and phase counters. On re-enable, a complete low phase of full length follows.
- R8: `wr_word_i` loads all 32 bits of `wdata_i` into `timing_o` by the next cycle. `wr_div_i` loads only bits 19:0 and keeps bits 31:20. When both are high, `wr_word_i` wins.
- R9: With `HL_W`=3, bits 19 and 15 are stored but have no effect on timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Generator enable |
| wr_word_i | input | 1 | Write the whole timing word |
| wr_div_i | input | 1 | Write bits 19:0 of the timing word only |
| wdata_i | input | 32 | Write data for the timing word |
| timing_o | output | 32 | Stored timing word |
| scl_drive_o | output | 1 | 1 = pull SCL low |
| scl_fall_o | output | 1 | First cycle of a low phase |
| scl_rise_o | output | 1 | First cycle of a high phase |
| mid_low_o | output | 1 | Middle of the low phase |
| mid_high_o | output | 1 | Middle of the high phase |

## Verification
The assertions assume that `en_i`, `wr_word_i` and `wr_div_i` are synchronous to `clk_i`. They also assume that the active configuration changes only at the cycle where a low phase begins. The prescaler bound check relies on the prescaler and phase logic switching the exponent together at that boundary. The stimulus changes inputs shortly after the falling clock edge, so the changes never overlap a sampling edge. Writes that must be deferred are placed inside a low phase that is at least several cycles long. Disables happen either just after the last planned event of a period or inside a long low phase, so that no expected event falls in the cycle where the enable drops.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int WORD_W   = 32;
  localparam int BASE_W   = 4;
  localparam int PRE_W    = (1 << BASE_W) - 1;
  localparam int BASE_LSB = 0;
  localparam int LO_LSB   = 12;
  localparam int HI_LSB   = 16;
  localparam int KEEP_LSB = 20;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;
endpackage

// File: rtl/scl_cfg_reg.sv
module scl_cfg_reg
  import scl_pkg::*;
#(
  parameter logic [WORD_W-1:0] RST_WORD = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_word_i,
  input  logic              wr_div_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] word_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        word_o <= RST_WORD;
    else if (wr_word_i) word_o <= wdata_i;
    else if (wr_div_i)  word_o[KEEP_LSB-1:0] <= wdata_i[KEEP_LSB-1:0];
  end

  assert_keep_upper_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_div_i && !wr_word_i) |=> $stable(word_o[WORD_W-1:KEEP_LSB]));

  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_div_i && !wr_word_i) |=> $stable(word_o));

  assert_word_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_word_i |=> (word_o == $past(wdata_i)));

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler
  import scl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [BASE_W-1:0] base_i,
  output logic [PRE_W-1:0]  cnt_o,
  output logic              last_o
);

  logic [PRE_W-1:0] lim;

  assign lim    = PRE_W'((32'd1 << base_i) - 32'd1);
  assign last_o = run_i && (cnt_o == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_o <= '0;
    else if (!run_i || last_o)  cnt_o <= '0;
    else                        cnt_o <= cnt_o + PRE_W'(1);
  end

  // exponent may only change while the count is at zero
  assert_pre_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_o <= lim));

  assert_pre_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_o == '0));

endmodule

// File: rtl/scl_phase_ctl.sv
module scl_phase_ctl
  import scl_pkg::*;
#(
  parameter int HL_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [HL_W-1:0]   hi_i,
  input  logic [HL_W-1:0]   lo_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic [PRE_W-1:0]  pre_cnt_i,
  input  logic              pre_last_i,
  output logic              run_o,
  output logic [BASE_W-1:0] base_o,
  output logic              drive_o,
  output logic              fall_o,
  output logic              rise_o,
  output logic              mid_low_o,
  output logic              mid_high_o
);

  localparam int EXT_W = HL_W + 1;

  phase_e            phase_q;
  logic [HL_W-1:0]   tk_q;
  logic [HL_W-1:0]   hi_q, lo_q;
  logic [BASE_W-1:0] base_q;
  logic [HL_W-1:0]   n_cur;
  logic [EXT_W-1:0]  n_ext;
  logic [HL_W-1:0]   mid_tk;
  logic [PRE_W-1:0]  mid_pre;
  logic              tk_last, start, at_edge, at_mid;

  assign n_cur   = (phase_q == PH_LOW) ? lo_q : hi_q;
  assign tk_last = (tk_q == n_cur);
  assign start   = en_i && ((phase_q == PH_IDLE) ||
                            (phase_q == PH_HIGH && pre_last_i && tk_last));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      tk_q    <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      base_q  <= '0;
    end else if (!en_i) begin
      phase_q <= PH_IDLE;
      tk_q    <= '0;
    end else if (start) begin
      phase_q <= PH_LOW;
      tk_q    <= '0;
      hi_q    <= hi_i;
      lo_q    <= lo_i;
      base_q  <= base_i;
    end else if (pre_last_i) begin
      if (tk_last) begin
        tk_q    <= '0;
        phase_q <= PH_HIGH;
      end else begin
        tk_q <= tk_q + HL_W'(1);
      end
    end
  end

  // half-phase offset split into tick index and prescaler residue
  assign n_ext  = {1'b0, n_cur} + EXT_W'(1);
  assign mid_tk = n_ext[EXT_W-1:1];
  always_comb begin
    mid_pre = '0;
    if (base_q != '0 && n_ext[0]) mid_pre = PRE_W'(32'd1 << (base_q - BASE_W'(1)));
  end

  assign at_edge    = (tk_q == '0) && (pre_cnt_i == '0);
  assign at_mid     = (tk_q == mid_tk) && (pre_cnt_i == mid_pre);
  assign run_o      = en_i && (phase_q != PH_IDLE);
  assign base_o     = base_q;
  assign drive_o    = (phase_q == PH_LOW);
  assign fall_o     = (phase_q == PH_LOW)  && at_edge;
  assign rise_o     = (phase_q == PH_HIGH) && at_edge;
  assign mid_low_o  = (phase_q == PH_LOW)  && at_mid;
  assign mid_high_o = (phase_q == PH_HIGH) && at_mid;

  assert_off_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!drive_o && !fall_o && !rise_o && !mid_low_o && !mid_high_o));

  assert_fall_on_drive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drive_o) |-> fall_o);

  assert_rise_on_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(drive_o) && phase_q == PH_HIGH) |-> rise_o);

  assert_cfg_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start |=> $stable({hi_q, lo_q, base_q}));

  assert_tick_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_IDLE) |-> (tk_q <= n_cur));

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_pkg::*;
#(
  parameter int                HL_W     = 4,
  parameter logic [WORD_W-1:0] RST_WORD = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_word_i,
  input  logic              wr_div_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] timing_o,
  output logic              scl_drive_o,
  output logic              scl_fall_o,
  output logic              scl_rise_o,
  output logic              mid_low_o,
  output logic              mid_high_o
);

  // only the 3-bit and 4-bit field variants exist
  localparam int FW = (HL_W < 3) ? 3 : ((HL_W > 4) ? 4 : HL_W);

  logic [WORD_W-1:0] word;
  logic              run, pre_last;
  logic [BASE_W-1:0] base_act;
  logic [PRE_W-1:0]  pre_cnt;

  scl_cfg_reg #(.RST_WORD(RST_WORD)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_word_i (wr_word_i),
    .wr_div_i  (wr_div_i),
    .wdata_i   (wdata_i),
    .word_o    (word)
  );

  assign timing_o = word;

  scl_prescaler u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .base_i (base_act),
    .cnt_o  (pre_cnt),
    .last_o (pre_last)
  );

  scl_phase_ctl #(.HL_W(FW)) u_ph (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .hi_i       (word[HI_LSB +: FW]),
    .lo_i       (word[LO_LSB +: FW]),
    .base_i     (word[BASE_LSB +: BASE_W]),
    .pre_cnt_i  (pre_cnt),
    .pre_last_i (pre_last),
    .run_o      (run),
    .base_o     (base_act),
    .drive_o    (scl_drive_o),
    .fall_o     (scl_fall_o),
    .rise_o     (scl_rise_o),
    .mid_low_o  (mid_low_o),
    .mid_high_o (mid_high_o)
  );

endmodule

// File: tb/sim_scl_timing_gen.sv
module sim_scl_timing_gen;

  typedef struct {
    int    kind;
    int    at;
    string rq;
  } ev_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, wr_word = 1'b0, wr_div = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] timing;
  logic        drive, fall, rise, ml, mh;
  logic        en1 = 1'b0, wr1 = 1'b0;
  logic [31:0] timing1;
  logic        drive1, fall1, rise1, ml1, mh1;

  int n_run = 0, n_fail = 0, cyc = 0, next_fall = 0;
  ev_t exp_q[$];

  always #10ns clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  scl_timing_gen #(.HL_W(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .wr_word_i(wr_word), .wr_div_i(wr_div),
    .wdata_i(wdata), .timing_o(timing), .scl_drive_o(drive), .scl_fall_o(fall),
    .scl_rise_o(rise), .mid_low_o(ml), .mid_high_o(mh));

  scl_timing_gen #(.HL_W(3)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en1), .wr_word_i(wr1), .wr_div_i(1'b0),
    .wdata_i(wdata), .timing_o(timing1), .scl_drive_o(drive1), .scl_fall_o(fall1),
    .scl_rise_o(rise1), .mid_low_o(ml1), .mid_high_o(mh1));

  function automatic string kname(input int k);
    case (k)
      0: return "fall";
      1: return "mid_low";
      2: return "rise";
      default: return "mid_high";
    endcase
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input string act, input string expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %s expected %s", rq, what, act, expv);
    end
  endtask

  // monitor: pops expected events as strobes appear
  always @(negedge clk) begin
    logic [3:0] seen;
    ev_t e;
    if (rst_n) begin
      seen = {mh, rise, ml, fall};
      for (int k = 0; k < 4; k++) begin
        if (seen[k]) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R1", "unexpected strobe",
                  $sformatf("%s@%0d", kname(k), cyc), "none");
          end else begin
            e = exp_q.pop_front();
            check(e.kind == k && e.at == cyc, e.rq, "strobe",
                  $sformatf("%s@%0d", kname(k), cyc),
                  $sformatf("%s@%0d", kname(e.kind), e.at));
          end
          if (k == 0) check(drive == 1'b1, "R2", "drive at fall", $sformatf("%0b", drive), "1");
          if (k == 2) check(drive == 1'b0, "R2", "drive at rise", $sformatf("%0b", drive), "0");
        end
      end
    end
  end

  task automatic step();
    @(negedge clk);
    #2ns;
  endtask

  function automatic logic [31:0] mkword(input int b, input int h, input int l,
                                         input logic [11:0] up);
    return {up, 4'(h), 4'(l), 8'h5A, 4'(b)};
  endfunction

  task automatic plan_period(input int b, input int h, input int l, input string rq);
    int ll, lh;
    ll = (l + 1) << b;
    lh = (h + 1) << b;
    exp_q.push_back('{0, next_fall, rq});
    exp_q.push_back('{1, next_fall + ll / 2, rq});
    exp_q.push_back('{2, next_fall + ll, rq});
    exp_q.push_back('{3, next_fall + ll + lh / 2, rq});
    next_fall += ll + lh;
  endtask

  task automatic write_word(input logic [31:0] w);
    wdata = w; wr_word = 1'b1;
    step();
    wr_word = 1'b0;
    check(timing == w, "R8", "word write", $sformatf("%h", timing), $sformatf("%h", w));
  endtask

  task automatic enable();
    en = 1'b1;
    next_fall = cyc + 1;
  endtask

  task automatic drain_and_stop();
    while (exp_q.size() != 0) step();
    en = 1'b0;
    step();
    check(drive == 1'b0, "R1", "drive after disable", $sformatf("%0b", drive), "0");
  endtask

  initial begin
    #3ms;
    n_fail++;
    $display("FAIL R1 watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int f1, r1, f2, t0;
    logic [31:0] wb;
    repeat (3) step();
    check({drive, fall, rise, ml, mh} == 5'b0, "R1", "outputs in reset",
          $sformatf("%b", {drive, fall, rise, ml, mh}), "00000");
    check(timing == 32'h0, "R8", "reset word", $sformatf("%h", timing), "0");
    rst_n = 1'b1;
    step();

    // R2/R3: base 1, hi 2, lo 3; then divisor-only write deferred to next period (R6)
    write_word(mkword(1, 2, 3, 12'hA5C));
    enable();
    t0 = next_fall;
    plan_period(1, 2, 3, "R2");
    step(); step();
    wb = mkword(0, 2, 1, 12'hFFF);
    wdata = wb; wr_div = 1'b1;
    step();
    wr_div = 1'b0;
    check(timing == {12'hA5C, wb[19:0]}, "R8", "divisor write keeps upper",
          $sformatf("%h", timing), $sformatf("%h", {12'hA5C, wb[19:0]}));
    check(cyc < t0 + 8, "R6", "write inside first low phase", $sformatf("%0d", cyc),
          $sformatf("<%0d", t0 + 8));
    plan_period(0, 2, 1, "R6");
    plan_period(0, 2, 1, "R5");
    drain_and_stop();
    repeat (5) step();

    // R7: disable inside a long low phase, then restart from a full low phase
    write_word(mkword(2, 1, 3, 12'h123));
    enable();
    plan_period(2, 1, 3, "R7");
    while (cyc < next_fall - 24 + 3) step();
    en = 1'b0;
    exp_q.delete();
    step();
    check(drive == 1'b0, "R1", "released on disable", $sformatf("%0b", drive), "0");
    repeat (20) step();
    check(drive == 1'b0, "R1", "stays released", $sformatf("%0b", drive), "0");
    enable();
    plan_period(2, 1, 3, "R7");
    plan_period(2, 1, 3, "R7");
    drain_and_stop();

    // R5: one-cycle phases, mid coincides with edges
    write_word(mkword(0, 0, 0, 12'h000));
    enable();
    repeat (3) plan_period(0, 0, 0, "R5");
    drain_and_stop();

    // R5: odd counts with and without prescaling
    write_word(mkword(0, 4, 2, 12'h000));
    enable();
    plan_period(0, 4, 2, "R5");
    drain_and_stop();
    write_word(mkword(3, 4, 2, 12'h000));
    enable();
    plan_period(3, 4, 2, "R5");
    drain_and_stop();

    // R3: largest phase fields, then largest exponent
    write_word(mkword(2, 15, 15, 12'h000));
    enable();
    plan_period(2, 15, 15, "R3");
    drain_and_stop();
    write_word(mkword(15, 0, 0, 12'h000));
    enable();
    plan_period(15, 0, 0, "R3");
    drain_and_stop();

    // R8: word write wins over divisor write
    wb = mkword(5, 6, 7, 12'hDEF);
    wdata = wb; wr_word = 1'b1; wr_div = 1'b1;
    step();
    wr_word = 1'b0; wr_div = 1'b0;
    check(timing == wb, "R8", "both writes", $sformatf("%h", timing), $sformatf("%h", wb));

    // R9: narrow fields ignore bits 19 and 15 (hi 4'hF -> 7, lo 4'h8 -> 0)
    wb = {12'h000, 4'hF, 4'h8, 8'h00, 4'h0};
    wdata = wb; wr1 = 1'b1;
    step();
    wr1 = 1'b0;
    check(timing1 == wb, "R9", "narrow word stored", $sformatf("%h", timing1), $sformatf("%h", wb));
    en1 = 1'b1;
    f1 = -1; r1 = -1; f2 = -1;
    for (int i = 0; i < 40 && f1 < 0; i++) begin
      step();
      if (fall1) begin
        f1 = cyc;
        check(ml1 == 1'b1, "R9", "narrow mid_low at fall", $sformatf("%0b", ml1), "1");
      end
    end
    for (int i = 0; i < 40 && r1 < 0; i++) begin step(); if (rise1) r1 = cyc; end
    for (int i = 0; i < 40 && f2 < 0; i++) begin step(); if (fall1) f2 = cyc; end
    en1 = 1'b0;
    check(r1 - f1 == 1, "R9", "narrow low length", $sformatf("%0d", r1 - f1), "1");
    check(f2 - r1 == 8, "R9", "narrow high length", $sformatf("%0d", f2 - r1), "8");
    repeat (3) step();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule